// File: doc/BRIEF.md
# Phase-Accumulator Serial Transmitter

This block turns bytes from a transmit queue into asynchronous serial frames. The bit rate is set by a 16-bit increment that is added to a 16-bit phase accumulator on every clock. Each carry out of the accumulator is an oversampling tick, and sixteen ticks make one bit time. The line rate is therefore increment × f_clk / 2^20. A coarse divider cannot reach the same set of rates.

A frame has ten bit times on the line: a low start bit, eight data bits with the least significant bit first, and a high stop bit. While transmission is enabled and no frame is in progress, the block pops one byte from the queue and starts a frame. It only fetches the next byte after the stop bit of the current frame has run its full length. If the enable is dropped during a frame, that frame still completes and no further byte is fetched. An idle flag tells software when the line is quiet and nothing is waiting in the queue.

Top module: `uart_nco_tx`

## Requirements
- R1: After reset the serial line is high, no pop is requested, and the idle flag is high while the queue reports empty.
- R2: The rate increment `nco_inc_i` (the field that sits in control bits 31:16) is added to a 16-bit accumulator every clock, and a bit lasts 16 accumulator carries. An increment of 0x8000 gives 32 clocks per bit and a frame period of 320 clocks. An increment of 0x4000 gives 64 clocks per bit and 640 clocks per frame.
- R3: A frame is a low start bit, then data bits 0 through 7 in that order, then a high stop bit. The line is high whenever no frame is in progress.
- R4: A byte is popped, with a one-cycle `fifo_pop_o` pulse, only while `tx_en_i` is high, the queue is not empty and no frame is in progress. With the enable low, queued bytes stay in the queue and the line stays high.
- R5: The next byte is fetched only after the stop bit has lasted its full 16 ticks. Frames sent back to back therefore start one frame period apart.
- R6: Clearing `tx_en_i` during a frame lets that frame finish intact. After it, no further byte is popped until the enable is set again.
- R7: `idle_o` is high exactly when no frame is in progress and the queue is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| nco_inc_i | input | 16 | Rate increment (control bits 31:16) |
| tx_en_i | input | 1 | Transmit enable |
| fifo_empty_i | input | 1 | Transmit queue is empty |
| fifo_data_i | input | 8 | Byte at the head of the queue |
| fifo_pop_o | output | 1 | Pop the head byte this cycle |
| txd_o | output | 1 | Serial line output |
| idle_o | output | 1 | No frame in progress and queue empty |

## Verification
A fault in the oversampling count or in the bit counter shows up at the ports within one frame. It stretches or shortens the bit times, which moves the start of the next frame away from the 320- or 640-clock spacing, or it shifts data so that received bytes come out rotated. A corrupted shift register shows up in the very next sampled data bit. A fault in the fetch condition appears as an extra or missing pop pulse within a few cycles of the enable or the queue changing. The same fault also changes `idle_o`, because that flag depends on both the frame state and the queue state.

// File: rtl/uart_nco_pkg.sv
package uart_nco_pkg;
  typedef enum logic {
    TX_IDLE = 1'b0,
    TX_SEND = 1'b1
  } tx_state_e;

  localparam int unsigned NCO_W    = 16;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned OVERSAMP = 16;
endpackage

// File: rtl/uart_nco_tick.sv
module uart_nco_tick #(
  parameter int unsigned ACC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] inc_i,
  output logic             tick_o
);
  logic [ACC_W-1:0] acc_q, acc_d;
  logic             carry;

  always_comb begin
    {carry, acc_d} = {1'b0, acc_q} + {1'b0, inc_i};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_o <= 1'b0;
    end else begin
      acc_q  <= acc_d;
      tick_o <= carry;
    end
  end

  // R2: with increments at or below half scale, two carries never come back to back
  a_r2_tick_spacing: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && ({1'b0, inc_i} <= (1 << (ACC_W-1))) && ({1'b0, $past(inc_i)} <= (1 << (ACC_W-1))))
      |=> !tick_o);
endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
  import uart_nco_pkg::*;
#(
  parameter int unsigned DW  = 8,
  parameter int unsigned OVS = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          en_i,
  input  logic          empty_i,
  input  logic [DW-1:0] data_i,
  output logic          pop_o,
  output logic          busy_o,
  output logic          txd_o
);
  localparam int unsigned FRAME_W = DW + 2;
  localparam int unsigned SUB_W   = $clog2(OVS);
  localparam int unsigned CNT_W   = $clog2(FRAME_W);

  tx_state_e          state_q, state_d;
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [SUB_W-1:0]   sub_q, sub_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               bit_end;

  assign bit_end = tick_i && (sub_q == SUB_W'(OVS - 1));

  always_comb begin
    state_d = state_q;
    sh_d    = sh_q;
    sub_d   = sub_q;
    cnt_d   = cnt_q;
    pop_o   = 1'b0;
    case (state_q)
      TX_IDLE: begin
        if (en_i && !empty_i) begin
          pop_o   = 1'b1;
          sh_d    = {1'b1, data_i, 1'b0};
          sub_d   = '0;
          cnt_d   = '0;
          state_d = TX_SEND;
        end
      end
      TX_SEND: begin
        if (bit_end) begin
          sub_d = '0;
          sh_d  = {1'b1, sh_q[FRAME_W-1:1]};
          if (cnt_q == CNT_W'(FRAME_W - 1)) begin
            state_d = TX_IDLE;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end else if (tick_i) begin
          sub_d = sub_q + 1'b1;
        end
      end
      default: state_d = TX_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      sh_q    <= '1;
      sub_q   <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      sh_q    <= sh_d;
      sub_q   <= sub_d;
      cnt_q   <= cnt_d;
    end
  end

  assign busy_o = (state_q == TX_SEND);
  assign txd_o  = busy_o ? sh_q[0] : 1'b1;

  // R4: a pop is a single-cycle pulse and starts a frame
  a_r4_pop_starts_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_o |=> (busy_o && !pop_o));
  // R3: every frame opens with a low start bit
  a_r3_start_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> !txd_o);
  // R5: a frame ends only on a bit boundary after its last bit
  a_r5_end_on_boundary: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> ($past(tick_i) && $past(txd_o)));
  // R3: bit index never passes the stop bit
  a_r3_count_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(FRAME_W - 1));
endmodule

// File: rtl/uart_nco_tx.sv
module uart_nco_tx
  import uart_nco_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NCO_W-1:0]  nco_inc_i,
  input  logic              tx_en_i,
  input  logic              fifo_empty_i,
  input  logic [DATA_W-1:0] fifo_data_i,
  output logic              fifo_pop_o,
  output logic              txd_o,
  output logic              idle_o
);
  logic tick;
  logic busy;

  uart_nco_tick #(.ACC_W(NCO_W)) u_tick (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .inc_i  (nco_inc_i),
    .tick_o (tick)
  );

  uart_tx_frame #(.DW(DATA_W), .OVS(OVERSAMP)) u_frame (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .tick_i  (tick),
    .en_i    (tx_en_i),
    .empty_i (fifo_empty_i),
    .data_i  (fifo_data_i),
    .pop_o   (fifo_pop_o),
    .busy_o  (busy),
    .txd_o   (txd_o)
  );

  assign idle_o = !busy && fifo_empty_i;

  // R7: an idle block leaves the line high
  a_r7_idle_line_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> txd_o);
  // R6: a popped byte is never pulled while the enable is low
  a_r6_no_pop_disabled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_en_i |-> !fifo_pop_o);
endmodule

// File: tb/uart_nco_tx_bench.sv
module uart_nco_tx_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] nco;
  logic        en;
  logic        pop;
  logic        txd;
  logic        idle;
  logic [7:0]  fmem [16];
  logic [3:0]  wr_p;
  logic [3:0]  rd_p;
  logic        empty;
  int          pops;
  int          cyc;
  int          total = 0;
  int          bad = 0;

  always #5 clk = ~clk;

  assign empty = (wr_p == rd_p);

  uart_nco_tx u_uart_nco_tx (
    .clk_i        (clk),
    .rst_ni       (rst_n),
    .nco_inc_i    (nco),
    .tx_en_i      (en),
    .fifo_empty_i (empty),
    .fifo_data_i  (fmem[rd_p]),
    .fifo_pop_o   (pop),
    .txd_o        (txd),
    .idle_o       (idle)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_p <= '0;
      pops <= 0;
    end else if (pop) begin
      rd_p <= rd_p + 1'b1;
      pops <= pops + 1;
    end
  end

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_rng(input string req, input int act, input int lo, input int hi);
    total++;
    if (act < lo || act > hi) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d..%0d", req, act, lo, hi);
    end
  endtask

  task automatic push(input logic [7:0] b);
    @(negedge clk);
    fmem[wr_p] = b;
    wr_p = wr_p + 1'b1;
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Waits for a start edge, then samples each bit at its centre
  task automatic recv(input int bitc, input bit drop_en,
                      output logic [7:0] b, output int t0, output bit ok);
    int w = 0;
    ok = 1'b1;
    b  = '0;
    @(negedge clk);
    while (txd && w < 20 * bitc) begin
      @(negedge clk);
      w++;
    end
    t0 = cyc;
    if (txd) begin
      ok = 1'b0;
      return;
    end
    if (drop_en) en = 1'b0;
    wait_cyc(bitc / 2);
    if (txd) ok = 1'b0;
    for (int k = 0; k < 8; k++) begin
      wait_cyc(bitc);
      b[k] = txd;
    end
    wait_cyc(bitc);
    if (!txd) ok = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    nco   = 16'h8000;
    en    = 1'b0;
    wr_p  = '0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(2);
    check("R1 line high", txd, 1);
    check("R1 no pop", pop, 0);
    check("R1 idle", idle, 1);
  endtask

  task automatic t_single();
    logic [7:0] b; int t0; bit ok;
    push(8'hA5);
    en = 1'b1;
    wait_cyc(1);
    check("R7 not idle with data", idle, 0);
    recv(32, 1'b0, b, t0, ok);
    check("R3 framing", ok, 1);
    check("R3 data lsb first", b, 8'hA5);
    wait_cyc(32);
    check("R7 idle after frame", idle, 1);
    check("R4 one pop", pops, 1);
  endtask

  task automatic t_back_to_back(input logic [15:0] inc, input int bitc);
    logic [7:0] b1, b2; int t1, t2; bit ok1, ok2; int p0;
    en  = 1'b0;
    nco = inc;
    p0  = pops;
    push(8'h3C);
    push(8'hC1);
    en = 1'b1;
    recv(bitc, 1'b0, b1, t1, ok1);
    recv(bitc, 1'b0, b2, t2, ok2);
    check("R3 first frame", {ok1, b1}, {1'b1, 8'h3C});
    check("R3 second frame", {ok2, b2}, {1'b1, 8'hC1});
    check_rng(bitc == 32 ? "R5 frame spacing 0x8000" : "R2 frame spacing 0x4000",
              t2 - t1, 10 * bitc - 2, 10 * bitc + 4);
    wait_cyc(bitc);
    check("R4 two pops", pops - p0, 2);
  endtask

  task automatic t_gate();
    logic [7:0] b; int t0; bit ok; int p0; bit hi;
    en  = 1'b0;
    nco = 16'h8000;
    p0  = pops;
    push(8'h55);
    hi = 1'b1;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (!txd) hi = 1'b0;
    end
    check("R4 no pop while disabled", pops - p0, 0);
    check("R4 line held high", hi, 1);
    check("R7 not idle, queue holds data", idle, 0);
    en = 1'b1;
    recv(32, 1'b0, b, t0, ok);
    check("R4 byte sent after enable", {ok, b}, {1'b1, 8'h55});
    check("R4 single pop", pops - p0, 1);
  endtask

  task automatic t_drop_en();
    logic [7:0] b; int t0; bit ok; int p0; bit hi;
    wait_cyc(40);
    p0 = pops;
    en = 1'b0;
    push(8'h81);
    push(8'h7E);
    en = 1'b1;
    recv(32, 1'b1, b, t0, ok);
    check("R6 frame finishes", {ok, b}, {1'b1, 8'h81});
    hi = 1'b1;
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (!txd) hi = 1'b0;
    end
    check("R6 no further frame", hi, 1);
    check("R6 no further pop", pops - p0, 1);
    check("R7 idle low with queued byte", idle, 0);
    en = 1'b1;
    recv(32, 1'b0, b, t0, ok);
    check("R6 resumes on enable", {ok, b}, {1'b1, 8'h7E});
    wait_cyc(32);
    check("R7 idle after drain", idle, 1);
  endtask

  initial begin
    #(200000 * 10);
    bad++;
    total++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc = 0;
    t_reset();
    t_single();
    t_back_to_back(16'h8000, 32);
    t_back_to_back(16'h4000, 64);
    t_gate();
    t_drop_en();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule